// File: doc/BRIEF.md
# Interrupt Redirection and Message Delivery Engine

This block turns a vector of interrupt request wires into message-signalled interrupts. For each input pin it keeps one redirection entry. The entry holds a vector number, a delivery mode, a destination field, a destination-mode bit, a trigger-mode bit and a mask bit. A pending register records which pins are asking for service. A priority picker then chooses the lowest-numbered pin that may be served. The block packs that pin's entry into a 32-bit address and a 32-bit data word and offers them on a valid/ready output.

Edge pins and level pins follow different rules. An edge pin is latched on a rising edge only when its entry is unmasked at that moment, and it is released once its message goes out. A level pin's pending bit follows the wire. When a level message goes out, the block sets a per-entry in-service flag (remote IRR), and no further message is sent for that pin while the flag is set. An end-of-interrupt strobe that carries a vector clears the flag on every level entry programmed with that vector.

A separate register window reads and writes the entries one 32-bit half at a time through a simple indexed port.

Top module: `irq_redir_engine`

## Requirements
- R1: After reset every entry is masked and edge-triggered, with all other fields and the remote IRR flag at zero, so the low half reads back 0x0001_0000. `msg_valid` is low, and no pin activity produces a message until an entry is unmasked.
- R2: A write with `cfg_hi`=0 stores vector [7:0], delivery mode [10:8], destination mode [11], trigger [15] (1 = level) and mask [16]. A write with `cfg_hi`=1 stores the destination from data [31:16]. `cfg_rdata` returns the entry selected by `cfg_idx`/`cfg_hi` one cycle later, in the same layout, with remote IRR at bit 14 and every other bit reading 0. Remote IRR cannot be written. An index of 24 or above is ignored on write and reads as 0.
- R3: A message address is 0xFEE0_0000 OR destination<<4 OR destination mode<<2. The data word is vector OR delivery mode<<8 OR trigger<<15.
- R4: A rising edge on an edge pin whose entry is masked at that time is discarded. Unmasking the entry later sends nothing.
- R5: For a level entry, the pending bit follows the input. Delivery sets remote IRR, and while remote IRR is set no further message is sent for that pin, even with the input held high.
- R6: An end-of-interrupt strobe clears remote IRR on every level entry whose vector equals `eoi_vector`. Entries with another vector are unaffected. If the input is still high after the clear, the pin is delivered again.
- R7: A masked level entry with its input high sends nothing but stays pending. Unmasking it sends the message.
- R8: Input pin 0 is routed to entry 2, ORed with input pin 2. Entry 0 has no input and never sends.
- R9: When several pins are eligible, the lowest entry index is sent first, one message per accepted transfer. While `msg_valid` is high and `msg_ready` is low, the address and data hold steady.
- R10: Writing a low half whose trigger bit is 0 (edge) clears that entry's remote IRR.
- R11: One rising edge on an unmasked edge pin yields exactly one message, however long the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pins | input | NPINS | Interrupt request inputs, synchronous to clk |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | IDXW | Entry index for read and write |
| cfg_hi | input | 1 | Selects the upper (1) or lower (0) half of the entry |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt strobe |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Sink accepts the message |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
A corrupted pending bit shows up within about three cycles as a missing, duplicated or out-of-order message, and a scoreboard of expected address/data pairs catches it. A remote IRR flag stuck high or low shows up as a level interrupt that never returns after end-of-interrupt, or one that repeats while the input is held. Register readback shows the flag on the next cycle. Stalls are injected on the output so that holding behaviour and lowest-first ordering are exercised with several pins pending at once.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int VEC_W  = 8;
  localparam int DM_W   = 3;
  localparam int DEST_W = 16;

  // low-half field positions
  localparam int LO_VEC_LSB = 0;
  localparam int LO_DM_LSB  = 8;
  localparam int LO_DMODE_B = 11;
  localparam int LO_RIRR_B  = 14;
  localparam int LO_TRIG_B  = 15;
  localparam int LO_MASK_B  = 16;
  // high-half field position
  localparam int HI_DEST_LSB = 16;

  // message packing
  localparam logic [31:0] MSG_BASE = 32'hFEE0_0000;
  localparam int ADDR_DEST_SH  = 4;
  localparam int ADDR_DMODE_SH = 2;
  localparam int DATA_DM_SH    = 8;
  localparam int DATA_TRIG_SH  = 15;

  function automatic logic [31:0] pack_addr(input logic [DEST_W-1:0] dest, input logic dmode);
    return MSG_BASE | (32'(dest) << ADDR_DEST_SH) | (32'(dmode) << ADDR_DMODE_SH);
  endfunction

  function automatic logic [31:0] pack_data(input logic [VEC_W-1:0] vec,
                                            input logic [DM_W-1:0] dm, input logic trig);
    return 32'(vec) | (32'(dm) << DATA_DM_SH) | (32'(trig) << DATA_TRIG_SH);
  endfunction

  function automatic logic [31:0] pack_lo(input logic mask, input logic trig, input logic rirr,
                                          input logic dmode, input logic [DM_W-1:0] dm,
                                          input logic [VEC_W-1:0] vec);
    logic [31:0] w;
    w = '0;
    w[LO_VEC_LSB +: VEC_W] = vec;
    w[LO_DM_LSB +: DM_W]   = dm;
    w[LO_DMODE_B]          = dmode;
    w[LO_RIRR_B]           = rirr;
    w[LO_TRIG_B]           = trig;
    w[LO_MASK_B]           = mask;
    return w;
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int NPINS     = 24,
  parameter int ROUTE_SRC = 0,
  parameter int ROUTE_DST = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins_i,
  output logic [NPINS-1:0] lvl_o,
  output logic [NPINS-1:0] rise_o
);
  logic [NPINS-1:0] routed;
  logic [NPINS-1:0] cur_q;
  logic [NPINS-1:0] old_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_route
    if (g == ROUTE_DST) begin : g_dst
      assign routed[g] = pins_i[g] | pins_i[ROUTE_SRC];
    end else if (g == ROUTE_SRC) begin : g_src
      assign routed[g] = 1'b0;
    end else begin : g_straight
      assign routed[g] = pins_i[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      old_q <= '0;
    end else begin
      cur_q <= routed;
      old_q <= cur_q;
    end
  end

  assign lvl_o  = cur_q;
  assign rise_o = cur_q & ~old_q;
endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_redir_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IDXW  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDXW-1:0]   cfg_idx,
  input  logic              cfg_hi,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              set_en,
  input  logic [IDXW-1:0]   set_idx,
  input  logic              eoi_en,
  input  logic [VEC_W-1:0]  eoi_vec,
  input  logic [IDXW-1:0]   sel_idx,
  output logic [VEC_W-1:0]  sel_vec,
  output logic [DM_W-1:0]   sel_dm,
  output logic              sel_dmode,
  output logic [DEST_W-1:0] sel_dest,
  output logic [NPINS-1:0]  mask_o,
  output logic [NPINS-1:0]  trig_o,
  output logic [NPINS-1:0]  rirr_o
);
  logic [VEC_W-1:0]  vec_q  [NPINS];
  logic [DM_W-1:0]   dm_q   [NPINS];
  logic [DEST_W-1:0] dest_q [NPINS];
  logic [NPINS-1:0]  dmode_q, mask_q, trig_q, rirr_q, rirr_nxt;
  logic              idx_ok, wr_ok;
  logic              unused_wr_bits;

  assign idx_ok = int'(cfg_idx) < NPINS;
  assign wr_ok  = cfg_we && idx_ok;
  assign unused_wr_bits = ^cfg_wdata[LO_RIRR_B:12];

  always_comb begin
    for (int n = 0; n < NPINS; n++) begin
      rirr_nxt[n] = rirr_q[n];
      if (eoi_en && trig_q[n] && (vec_q[n] == eoi_vec)) rirr_nxt[n] = 1'b0;
      if (set_en && (set_idx == IDXW'(n))) rirr_nxt[n] = 1'b1;
      if (wr_ok && !cfg_hi && (cfg_idx == IDXW'(n)) && !cfg_wdata[LO_TRIG_B])
        rirr_nxt[n] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NPINS; n++) begin
        vec_q[n]  <= '0;
        dm_q[n]   <= '0;
        dest_q[n] <= '0;
      end
      dmode_q <= '0;
      mask_q  <= '1;
      trig_q  <= '0;
      rirr_q  <= '0;
    end else begin
      for (int n = 0; n < NPINS; n++) begin
        if (wr_ok && (cfg_idx == IDXW'(n))) begin
          if (cfg_hi) begin
            dest_q[n] <= cfg_wdata[HI_DEST_LSB +: DEST_W];
          end else begin
            vec_q[n]   <= cfg_wdata[LO_VEC_LSB +: VEC_W];
            dm_q[n]    <= cfg_wdata[LO_DM_LSB +: DM_W];
            dmode_q[n] <= cfg_wdata[LO_DMODE_B];
            trig_q[n]  <= cfg_wdata[LO_TRIG_B];
            mask_q[n]  <= cfg_wdata[LO_MASK_B];
          end
        end
      end
      rirr_q <= rirr_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (!idx_ok) begin
      cfg_rdata <= '0;
    end else if (cfg_hi) begin
      cfg_rdata <= {dest_q[cfg_idx], 16'h0000};
    end else begin
      cfg_rdata <= pack_lo(mask_q[cfg_idx], trig_q[cfg_idx], rirr_q[cfg_idx],
                           dmode_q[cfg_idx], dm_q[cfg_idx], vec_q[cfg_idx]);
    end
  end

  assign sel_vec   = vec_q[sel_idx];
  assign sel_dm    = dm_q[sel_idx];
  assign sel_dmode = dmode_q[sel_idx];
  assign sel_dest  = dest_q[sel_idx];
  assign mask_o    = mask_q;
  assign trig_o    = trig_q;
  assign rirr_o    = rirr_q;
endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
  parameter int NPINS = 24,
  parameter int IDXW  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] rise_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic [NPINS-1:0] trig_i,
  input  logic [NPINS-1:0] rirr_i,
  input  logic             take_i,
  output logic             pick_valid_o,
  output logic [IDXW-1:0]  pick_idx_o
);
  logic [NPINS-1:0] pend_q, pend_nxt, elig;

  always_comb begin
    for (int n = 0; n < NPINS; n++) begin
      if (trig_i[n]) begin
        pend_nxt[n] = lvl_i[n];
      end else begin
        pend_nxt[n] = pend_q[n];
        if (take_i && (pick_idx_o == IDXW'(n))) pend_nxt[n] = 1'b0;
        if (rise_i[n] && !mask_i[n]) pend_nxt[n] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt;
  end

  assign elig = pend_q & ~mask_i & ~(trig_i & rirr_i);

  always_comb begin
    pick_valid_o = 1'b0;
    pick_idx_o   = '0;
    for (int n = 0; n < NPINS; n++) begin
      if (elig[n] && !pick_valid_o) begin
        pick_valid_o = 1'b1;
        pick_idx_o   = IDXW'(n);
      end
    end
  end
endmodule

// File: rtl/irq_msg_out.sv
module irq_msg_out (
  input  logic        clk,
  input  logic        rst,
  input  logic        load_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] data_i,
  output logic        free_o,
  output logic        valid_o,
  input  logic        ready_i,
  output logic [31:0] addr_o,
  output logic [31:0] data_o
);
  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_redir_engine.sv
module irq_redir_engine
  import irq_redir_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IDXW  = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] irq_pins,
  input  logic             cfg_we,
  input  logic [IDXW-1:0]  cfg_idx,
  input  logic             cfg_hi,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             eoi_valid,
  input  logic [7:0]       eoi_vector,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [31:0]      msg_addr,
  output logic [31:0]      msg_data
);
  logic [NPINS-1:0]  lvl, rise, mask, trig, rirr;
  logic              pick_valid, take, out_free;
  logic [IDXW-1:0]   pick_idx;
  logic [VEC_W-1:0]  sel_vec;
  logic [DM_W-1:0]   sel_dm;
  logic              sel_dmode;
  logic [DEST_W-1:0] sel_dest;

  irq_pin_sync #(.NPINS(NPINS), .ROUTE_SRC(0), .ROUTE_DST(2)) u_sync (
    .clk(clk), .rst(rst), .pins_i(irq_pins), .lvl_o(lvl), .rise_o(rise)
  );

  irq_redir_table #(.NPINS(NPINS), .IDXW(IDXW)) u_table (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_hi(cfg_hi), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .set_en(take && trig[pick_idx]), .set_idx(pick_idx),
    .eoi_en(eoi_valid), .eoi_vec(eoi_vector),
    .sel_idx(pick_idx), .sel_vec(sel_vec), .sel_dm(sel_dm), .sel_dmode(sel_dmode),
    .sel_dest(sel_dest),
    .mask_o(mask), .trig_o(trig), .rirr_o(rirr)
  );

  irq_pend_arb #(.NPINS(NPINS), .IDXW(IDXW)) u_arb (
    .clk(clk), .rst(rst), .lvl_i(lvl), .rise_i(rise), .mask_i(mask), .trig_i(trig),
    .rirr_i(rirr), .take_i(take), .pick_valid_o(pick_valid), .pick_idx_o(pick_idx)
  );

  assign take = pick_valid && out_free;

  irq_msg_out u_out (
    .clk(clk), .rst(rst), .load_i(take),
    .addr_i(pack_addr(sel_dest, sel_dmode)),
    .data_i(pack_data(sel_vec, sel_dm, trig[pick_idx])),
    .free_o(out_free), .valid_o(msg_valid), .ready_i(msg_ready),
    .addr_o(msg_addr), .data_o(msg_data)
  );
endmodule

// File: rtl/irq_redir_engine_chk.sv
module irq_redir_engine_chk #(
  parameter int NPINS = 24,
  parameter int IDXW  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [31:0]      msg_addr,
  input logic [31:0]      msg_data,
  input logic             take,
  input logic [IDXW-1:0]  pick_idx,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] trig,
  input logic [NPINS-1:0] rirr
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !msg_valid); // R1
  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_addr[31:20] == 12'hFEE) && (msg_addr[1:0] == 2'b00) && !msg_addr[3]); // R3
  AST_DATA_FORM: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_data[14:11] == 4'h0) && (msg_data[31:16] == 16'h0)); // R3
  AST_LEVEL_SKIP: assert property (@(posedge clk) disable iff (rst)
    take && trig[pick_idx] |-> !rirr[pick_idx]); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    take |-> !mask[pick_idx]); // R7
  AST_PIN0_QUIET: assert property (@(posedge clk) disable iff (rst)
    take |-> (pick_idx != '0)); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R9
endmodule

bind irq_redir_engine irq_redir_engine_chk #(.NPINS(NPINS), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .take(take), .pick_idx(pick_idx),
  .mask(mask), .trig(trig), .rirr(rirr)
);

// File: tb/irq_redir_engine_tb.sv
module irq_redir_engine_tb;
  localparam int NP = 24;
  localparam int IW = 5;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] irq_pins = '0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic          cfg_hi = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          eoi_valid = 1'b0;
  logic [7:0]    eoi_vector = '0;
  logic          msg_valid;
  logic          msg_ready = 1'b1;
  logic [31:0]   msg_addr, msg_data;

  int    n_cmp = 0;
  int    n_bad = 0;
  exp_t  exp_q[$];
  string phase = "R1";
  bit    stall_en = 1'b0;
  bit    prev_stall = 1'b0;
  logic [31:0] prev_a, prev_d;

  always #5 clk = ~clk;

  irq_redir_engine #(.NPINS(NP)) u_dut (
    .clk(clk), .rst(rst), .irq_pins(irq_pins), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_hi(cfg_hi), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input int idx, input bit hi, input logic [31:0] w);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_hi = hi; cfg_wdata = w;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int idx, input bit hi, input logic [31:0] exp);
    cfg_idx = IW'(idx); cfg_hi = hi;
    tick(1);
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_valid = 1'b1; eoi_vector = v;
    tick(1);
    eoi_valid = 1'b0;
  endtask

  task automatic expect_msg(input string tag, input logic [31:0] a, input logic [31:0] d);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic drain(input string tag);
    tick(14);
    chk({tag, " outstanding"}, 32'(exp_q.size()), 32'd0);
  endtask

  // ready driver
  initial begin
    forever begin
      @(posedge clk);
      #1;
      msg_ready = stall_en ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        chk("R9 hold addr", msg_addr, prev_a);
        chk("R9 hold data", msg_data, prev_d);
      end
      if (msg_valid && msg_ready) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL %s: unexpected message actual 0x%08h/0x%08h expected none",
                   phase, msg_addr, msg_data);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({e.tag, " addr"}, msg_addr, e.a);
          chk({e.tag, " data"}, msg_data, e.d);
        end
      end
      prev_stall = msg_valid && !msg_ready;
      prev_a = msg_addr;
      prev_d = msg_data;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1: reset state
    chk("R1 valid", 32'(msg_valid), 32'd0);
    rd_chk("R1 lo", 5, 1'b0, 32'h0001_0000);
    rd_chk("R1 hi", 5, 1'b1, 32'h0000_0000);
    irq_pins = '1; tick(4); irq_pins = '0;
    drain("R1");

    // R2: register access
    phase = "R2";
    wr(5, 1'b0, 32'hFFFF_FFFF);
    rd_chk("R2 lo mask", 5, 1'b0, 32'h0001_8FFF);
    wr(5, 1'b1, 32'hABCD_1234);
    rd_chk("R2 hi", 5, 1'b1, 32'hABCD_0000);
    wr(30, 1'b0, 32'h0000_8077);
    rd_chk("R2 out of range", 30, 1'b0, 32'h0);
    wr(5, 1'b0, 32'h0001_0000);
    rd_chk("R2 restore", 5, 1'b0, 32'h0001_0000);

    // R3 / R11: edge delivery, format
    phase = "R11";
    wr(3, 1'b1, 32'h00A5_0000);
    wr(3, 1'b0, 32'h0000_0941);
    expect_msg("R3 edge", 32'hFEE0_0A54, 32'h0000_0141);
    irq_pins[3] = 1'b1; tick(10); irq_pins[3] = 1'b0;
    drain("R11");

    // R4: masked edge dropped
    phase = "R4";
    wr(3, 1'b0, 32'h0001_0941);
    irq_pins[3] = 1'b1; tick(3); irq_pins[3] = 1'b0; tick(2);
    wr(3, 1'b0, 32'h0000_0941);
    drain("R4");

    // R5 / R6: level with remote IRR
    phase = "R5";
    stall_en = 1'b1;
    wr(7, 1'b1, 32'h0003_0000);
    wr(7, 1'b0, 32'h0000_8052);
    expect_msg("R5 level", 32'hFEE0_0030, 32'h0000_8052);
    irq_pins[7] = 1'b1;
    drain("R5");
    rd_chk("R5 rirr set", 7, 1'b0, 32'h0000_C052);
    phase = "R6";
    expect_msg("R6 redeliver", 32'hFEE0_0030, 32'h0000_8052);
    eoi(8'h52);
    drain("R6");
    irq_pins[7] = 1'b0; tick(2);
    eoi(8'h52);
    drain("R6 low");
    rd_chk("R6 rirr clear", 7, 1'b0, 32'h0000_8052);
    expect_msg("R6 again", 32'hFEE0_0030, 32'h0000_8052);
    irq_pins[7] = 1'b1;
    drain("R6 again");
    eoi(8'h53);
    drain("R6 other vector");
    rd_chk("R6 other vector rirr", 7, 1'b0, 32'h0000_C052);
    irq_pins[7] = 1'b0; tick(2);
    eoi(8'h52);

    // R7: masked level keeps pending
    phase = "R7";
    wr(9, 1'b0, 32'h0001_8060);
    irq_pins[9] = 1'b1;
    drain("R7 masked");
    expect_msg("R7 unmask", 32'hFEE0_0000, 32'h0000_8060);
    wr(9, 1'b0, 32'h0000_8060);
    drain("R7 unmask");
    irq_pins[9] = 1'b0; tick(2);
    eoi(8'h60);

    // R10: switching to edge clears remote IRR
    phase = "R10";
    expect_msg("R10 level", 32'hFEE0_0030, 32'h0000_8052);
    irq_pins[7] = 1'b1;
    drain("R10");
    rd_chk("R10 set", 7, 1'b0, 32'h0000_C052);
    wr(7, 1'b0, 32'h0001_0052);
    rd_chk("R10 cleared", 7, 1'b0, 32'h0001_0052);
    irq_pins[7] = 1'b0;

    // R8: pin 0 routed to entry 2
    phase = "R8";
    wr(0, 1'b0, 32'h0000_0020);
    wr(2, 1'b0, 32'h0000_0022);
    expect_msg("R8 pin0", 32'hFEE0_0000, 32'h0000_0022);
    irq_pins[0] = 1'b1; tick(3); irq_pins[0] = 1'b0;
    drain("R8 pin0");
    expect_msg("R8 pin2", 32'hFEE0_0000, 32'h0000_0022);
    irq_pins[2] = 1'b1; tick(3); irq_pins[2] = 1'b0;
    drain("R8 pin2");

    // R9: lowest index first under stalls
    phase = "R9";
    wr(4, 1'b0, 32'h0000_0034);
    wr(6, 1'b0, 32'h0000_0036);
    wr(10, 1'b0, 32'h0000_003A);
    expect_msg("R9 first", 32'hFEE0_0000, 32'h0000_0034);
    expect_msg("R9 second", 32'hFEE0_0000, 32'h0000_0036);
    expect_msg("R9 third", 32'hFEE0_0000, 32'h0000_003A);
    irq_pins[10] = 1'b1; irq_pins[6] = 1'b1; irq_pins[4] = 1'b1;
    tick(3);
    irq_pins = '0;
    drain("R9");
    stall_en = 1'b0;
    tick(2);
    summary();
  end
endmodule